// File: doc/BRIEF.md
# Segment Descriptor Loader

This block turns a 16-bit segment selector into the cached form of a segment (base, byte limit, access byte and flag nibble) for one of three target segment registers: code, stack or data. It checks the selector against the global or local descriptor table, then fetches the 8-byte descriptor as two 32-bit reads over a request/response interface. It decodes the scattered base and limit fields, validates the descriptor type against the target register, and returns either the cached values or a fault.

A load starts with a one-cycle `start_i` pulse while the block is idle. Pulses that arrive during a fetch are ignored. When real mode is selected, no memory is touched: the base is the selector shifted left by four and the limit is 0xFFFF. Every load ends with a one-cycle `done_o` pulse. At that pulse the outputs are valid, and they hold until the next completion. Faults come in two kinds: a general protection fault, and a distinct not-present fault. Both report the offending selector.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bit 2 selects the local table (1) or the global table (0), and bits 15:3 are the index. The descriptor address is the table base plus index times 8. The low word is read first at that address, then the high word at address plus 4, and the cached fields are taken from these two words.
- R2: When index*8+7 exceeds the selected table's limit, the load completes with a general protection fault and issues no read. A descriptor whose last byte equals the limit is fetched.
- R3: A selector whose bits 15:2 are zero is null. A null selector loaded into code (kind 0) or stack (kind 1) gives a general protection fault. Loaded into data (kind 2), it completes with `unusable_o`=1, no fault and no read. A local-table index 0 is not null.
- R4: With low word L and high word H, base = {H[31:24], H[7:0], L[31:16]}, the raw 20-bit limit = {H[19:16], L[15:0]}, access = H[15:8] and flags = H[23:20].
- R5: When flags bit 3 (granularity) is 1, the limit is {raw, 12'hFFF}. Otherwise it is the raw value zero-extended.
- R6: A descriptor with access bit 4 clear (system type) gives a general protection fault for every kind.
- R7: The code kind requires access bit 3 (executable) set. Otherwise it gives a general protection fault.
- R8: The stack kind requires access bit 3 clear and bit 1 (writable) set. Otherwise it gives a general protection fault.
- R9: The data kind rejects execute-only code (bit 3 set, bit 1 clear) with a general protection fault. Readable code and any data segment are accepted.
- R10: A nonzero value in flags bits 1:0 gives a general protection fault.
- R11: A descriptor that passes all type checks but has access bit 7 (present) clear gives the not-present fault: `fault_o`=1 and `fault_np_o`=1. General protection checks take priority over the present check. A general protection fault shows `fault_o`=1 and `fault_np_o`=0. On any fault, base, limit, access and flags read as zero.
- R12: In real mode the load completes one cycle after start with no read. It returns base = selector*16, limit 0x0000FFFF, access 0x93 and flags 0.
- R13: `rd_valid_o` stays high with a stable `rd_addr_o` until `rd_ready_i` is seen. `done_o` is a single-cycle pulse. `fault_sel_o` gives the selector of the last completed load. After reset, `done_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (taken only when idle) |
| real_mode_i | input | 1 | Use the real-mode shortcut |
| sel_i | input | 16 | Selector to load |
| kind_i | input | 2 | Target register: 0 code, 1 stack, 2 data |
| gdt_base_i | input | 32 | Global table base address |
| gdt_limit_i | input | 16 | Global table limit in bytes |
| ldt_base_i | input | 32 | Local table base address |
| ldt_limit_i | input | 16 | Local table limit in bytes |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read request byte address |
| rd_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 32 | Read data word |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Load faulted |
| fault_np_o | output | 1 | Fault is the not-present kind |
| fault_sel_o | output | 16 | Selector of the last completed load |
| unusable_o | output | 1 | Null selector accepted into a data register |
| base_o | output | 32 | Segment base |
| limit_o | output | 32 | Expanded segment limit |
| access_o | output | 8 | Access byte |
| flags_o | output | 4 | Flag nibble |

## Verification
A table of descriptors is loaded into each register kind. It pairs every kind with data, code, execute-only, read-only, system and non-present access bytes, so that a type rule wrongly applied to the wrong kind, or a present check done before the type checks, shows up as a wrong fault flag. Base and limit values use distinct bytes in every field, with granularity both set and clear, so a misplaced byte or a missed expansion appears in the outputs. Directed loads cover null selectors of all three kinds, local index 0, the exact table-limit boundary on both sides for both tables, the real-mode shortcut, and a stalled read request whose address must not move.

// File: rtl/segld_pkg.sv
`timescale 1ns/1ps
package segld_pkg;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int TLIM_W = IDX_W + 3;
  localparam int DW     = 32;

  typedef enum logic [1:0] {
    KIND_CODE  = 2'd0,
    KIND_STACK = 2'd1,
    KIND_DATA  = 2'd2
  } seg_kind_e;

  typedef struct packed {
    logic [DW-1:0] base;
    logic [DW-1:0] limit;
    logic [7:0]    access;
    logic [3:0]    flags;
  } seg_info_t;

  // base bytes are spread over both descriptor words
  function automatic logic [DW-1:0] pick_base(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    return {hi[31:24], hi[7:0], lo[31:16]};
  endfunction

  function automatic logic [DW-1:0] expand_limit(input logic [19:0] raw, input logic gran);
    return gran ? {raw, 12'hFFF} : {12'h000, raw};
  endfunction

  function automatic logic [DW-1:0] real_base(input logic [SEL_W-1:0] sel);
    return {12'h000, sel, 4'h0};
  endfunction
endpackage

// File: rtl/segld_sel_check.sv
`timescale 1ns/1ps
module segld_sel_check
  import segld_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [SEL_W-1:2]  sel_hi_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [TLIM_W-1:0] gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [TLIM_W-1:0] ldt_limit_i,
  output logic              is_null_o,
  output logic              oob_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [IDX_W-1:0]  idx;
  logic              use_ldt;
  logic [TLIM_W-1:0] last_byte;
  logic [TLIM_W-1:0] tbl_lim;
  logic [ADDR_W-1:0] tbl_base;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] b, input logic [IDX_W-1:0] i);
    return b + ADDR_W'({i, 3'b000});
  endfunction

  assign idx       = sel_hi_i[SEL_W-1:3];
  assign use_ldt   = sel_hi_i[2];
  assign last_byte = {idx, 3'b111};
  assign tbl_lim   = use_ldt ? ldt_limit_i : gdt_limit_i;
  assign tbl_base  = use_ldt ? ldt_base_i  : gdt_base_i;
  assign is_null_o = (sel_hi_i == '0);
  assign oob_o     = last_byte > tbl_lim;
  assign addr_o    = entry_addr(tbl_base, idx);
endmodule

// File: rtl/segld_desc_check.sv
`timescale 1ns/1ps
module segld_desc_check
  import segld_pkg::*;
(
  input  seg_kind_e     kind_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output seg_info_t     info_o,
  output logic          gp_o,
  output logic          np_o
);
  logic [7:0] acc;
  logic [3:0] fl;
  logic       is_sys, is_exec, is_wr, kind_bad, rsv_bad;

  assign acc     = hi_i[15:8];
  assign fl      = hi_i[23:20];
  assign is_sys  = !acc[4];
  assign is_exec = acc[3];
  assign is_wr   = acc[1];
  assign rsv_bad = (fl[1:0] != 2'b00);

  always_comb begin
    unique case (kind_i)
      KIND_CODE:  kind_bad = !is_exec;
      KIND_STACK: kind_bad = is_exec || !is_wr;
      KIND_DATA:  kind_bad = is_exec && !is_wr;
      default:    kind_bad = 1'b1;
    endcase
  end

  assign gp_o = is_sys || kind_bad || rsv_bad;
  assign np_o = !gp_o && !acc[7];

  always_comb begin
    info_o.base   = pick_base(lo_i, hi_i);
    info_o.limit  = expand_limit({hi_i[19:16], lo_i[15:0]}, fl[3]);
    info_o.access = acc;
    info_o.flags  = fl;
  end
endmodule

// File: rtl/seg_desc_loader.sv
`timescale 1ns/1ps
module seg_desc_loader
  import segld_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              real_mode_i,
  input  logic [15:0]       sel_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [15:0]       gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [15:0]       ldt_limit_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_np_o,
  output logic [15:0]       fault_sel_o,
  output logic              unusable_o,
  output logic [31:0]       base_o,
  output logic [31:0]       limit_o,
  output logic [7:0]        access_o,
  output logic [3:0]        flags_o
);
  typedef enum logic [2:0] {S_IDLE, S_REQ_LO, S_WAIT_LO, S_REQ_HI, S_WAIT_HI} st_e;

  st_e               st, st_n;
  logic [SEL_W-1:0]  sel_q, fin_sel, fsel_q;
  seg_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     lo_q;
  seg_info_t         info_q, fin_info, dc_info;
  logic              done_q, gp_q, np_q, unus_q;
  logic              fin, fin_gp, fin_np, fin_unus;
  logic              sc_null, sc_oob, dc_gp, dc_np;
  logic [ADDR_W-1:0] sc_addr;
  logic              ev_start;

  segld_sel_check #(.ADDR_W(ADDR_W)) i_sel (
    .sel_hi_i   (sel_i[SEL_W-1:2]),
    .gdt_base_i (gdt_base_i),
    .gdt_limit_i(gdt_limit_i),
    .ldt_base_i (ldt_base_i),
    .ldt_limit_i(ldt_limit_i),
    .is_null_o  (sc_null),
    .oob_o      (sc_oob),
    .addr_o     (sc_addr)
  );

  segld_desc_check i_desc (
    .kind_i(kind_q),
    .lo_i  (lo_q),
    .hi_i  (rsp_data_i),
    .info_o(dc_info),
    .gp_o  (dc_gp),
    .np_o  (dc_np)
  );

  assign ev_start = (st == S_IDLE) && start_i;

  always_comb begin
    st_n     = st;
    fin      = 1'b0;
    fin_info = '0;
    fin_gp   = 1'b0;
    fin_np   = 1'b0;
    fin_unus = 1'b0;
    fin_sel  = sel_q;
    unique case (st)
      S_IDLE: if (start_i) begin
        fin_sel = sel_i;
        if (real_mode_i) begin
          fin             = 1'b1;
          fin_info.base   = real_base(sel_i);
          fin_info.limit  = 32'h0000_FFFF;
          fin_info.access = 8'h93;
        end else if (sc_null && kind_i != KIND_DATA) begin
          fin    = 1'b1;
          fin_gp = 1'b1;
        end else if (sc_null) begin
          fin      = 1'b1;
          fin_unus = 1'b1;
        end else if (sc_oob) begin
          fin    = 1'b1;
          fin_gp = 1'b1;
        end else begin
          st_n = S_REQ_LO;
        end
      end
      S_REQ_LO:  if (rd_ready_i)  st_n = S_WAIT_LO;
      S_WAIT_LO: if (rsp_valid_i) st_n = S_REQ_HI;
      S_REQ_HI:  if (rd_ready_i)  st_n = S_WAIT_HI;
      S_WAIT_HI: if (rsp_valid_i) begin
        st_n   = S_IDLE;
        fin    = 1'b1;
        fin_gp = dc_gp;
        fin_np = dc_np;
        if (!dc_gp && !dc_np) fin_info = dc_info;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sel_q  <= '0;
      kind_q <= KIND_CODE;
      addr_q <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
      info_q <= '0;
      gp_q   <= 1'b0;
      np_q   <= 1'b0;
      unus_q <= 1'b0;
      fsel_q <= '0;
    end else begin
      st     <= st_n;
      done_q <= fin;
      if (ev_start) begin
        sel_q  <= sel_i;
        kind_q <= seg_kind_e'(kind_i);
        addr_q <= sc_addr;
      end
      if (st == S_WAIT_LO && rsp_valid_i) lo_q <= rsp_data_i;
      if (fin) begin
        info_q <= fin_info;
        gp_q   <= fin_gp;
        np_q   <= fin_np;
        unus_q <= fin_unus;
        fsel_q <= fin_sel;
      end
    end
  end

  assign rd_valid_o  = (st == S_REQ_LO) || (st == S_REQ_HI);
  assign rd_addr_o   = (st == S_REQ_HI) ? addr_q + ADDR_W'(4) : addr_q;
  assign done_o      = done_q;
  assign fault_o     = gp_q || np_q;
  assign fault_np_o  = np_q;
  assign fault_sel_o = fsel_q;
  assign unusable_o  = unus_q;
  assign base_o      = info_q.base;
  assign limit_o     = info_q.limit;
  assign access_o    = info_q.access;
  assign flags_o     = info_q.flags;

  // R13: request held with a steady address until accepted
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  // R13: completion is a single-cycle pulse
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R12: real mode completes next cycle with no read
  a_r12_real_short: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && real_mode_i |=> done_o && !rd_valid_o && !fault_o &&
      limit_o == 32'h0000_FFFF && base_o[3:0] == 4'h0);
  // R2: out-of-bounds selector faults without a read
  a_r2_oob_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !real_mode_i && !sc_null && sc_oob |=> done_o && fault_o && !fault_np_o && !rd_valid_o);
  // R3: null selector into a data register is accepted as unusable
  a_r3_null_data: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !real_mode_i && sc_null && kind_i == KIND_DATA |=> done_o && unusable_o && !fault_o);
  // R5: page granularity fills the low twelve limit bits
  a_r5_gran_fill: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o && flags_o[3] |-> limit_o[11:0] == 12'hFFF);
  // R8: anything accepted into the stack register is present writable data
  a_r8_stack_ok: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o && kind_q == KIND_STACK |-> access_o[7] && access_o[1] && !access_o[3]);
  // R11: not-present is a fault of its own kind
  a_r11_np_kind: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_np_o |-> fault_o && !unusable_o && access_o == 8'h00);
endmodule

// File: tb/test_seg_desc_loader.sv
`timescale 1ns/1ps
module test_seg_desc_loader;
  localparam logic [31:0] GDT_B = 32'h0001_0000;
  localparam logic [15:0] GDT_L = 16'h00FF;
  localparam logic [31:0] LDT_B = 32'h0020_0000;
  localparam logic [15:0] LDT_L = 16'h0017;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] sel;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        gp;
    logic        np;
    logic [31:0] base;
    logic [31:0] limit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0008, 32'h0000FFFF, 32'h00CF9A00, 1'b0, 1'b0, 32'h00000000, 32'hFFFFFFFF}, // R1 R4 R5 R7
    '{2'd2, 16'h0010, 32'h5678BCDE, 32'h124A9234, 1'b0, 1'b0, 32'h12345678, 32'h000ABCDE}, // R4 R5
    '{2'd1, 16'h001B, 32'h00000FFF, 32'h00809210, 1'b0, 1'b0, 32'h00100000, 32'h00FFFFFF}, // R8 R5
    '{2'd1, 16'h0020, 32'h0000FFFF, 32'h00009000, 1'b1, 1'b0, 32'h0, 32'h0},               // R8 read-only
    '{2'd1, 16'h0028, 32'h0000FFFF, 32'h00009A00, 1'b1, 1'b0, 32'h0, 32'h0},               // R8 code
    '{2'd0, 16'h0030, 32'h0000FFFF, 32'h00009200, 1'b1, 1'b0, 32'h0, 32'h0},               // R7 data
    '{2'd2, 16'h0038, 32'h0000FFFF, 32'h00009800, 1'b1, 1'b0, 32'h0, 32'h0},               // R9 exec-only
    '{2'd2, 16'h0040, 32'h0000FFFF, 32'h00409A00, 1'b0, 1'b0, 32'h00000000, 32'h0000FFFF}, // R9 readable code
    '{2'd2, 16'h0048, 32'h0000FFFF, 32'h00008900, 1'b1, 1'b0, 32'h0, 32'h0},               // R6 system
    '{2'd2, 16'h0050, 32'h0000FFFF, 32'h00001200, 1'b0, 1'b1, 32'h0, 32'h0},               // R11 not present
    '{2'd0, 16'h0058, 32'h0000FFFF, 32'h00000900, 1'b1, 1'b0, 32'h0, 32'h0},               // R11 R6 priority
    '{2'd2, 16'h000C, 32'h00000010, 32'h00409200, 1'b0, 1'b0, 32'h00000000, 32'h00000010}, // R1 local table
    '{2'd2, 16'h0060, 32'h0000FFFF, 32'h00509200, 1'b1, 1'b0, 32'h0, 32'h0},               // R10 reserved flag
    '{2'd1, 16'h0068, 32'h0000FFFF, 32'h00001200, 1'b0, 1'b1, 32'h0, 32'h0}                // R11 stack np
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, real_mode_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [1:0]  kind_i = '0;
  logic        rd_valid_o, rd_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic [31:0] rd_addr_o, rsp_data_i = '0;
  logic        done_o, fault_o, fault_np_o, unusable_o;
  logic [15:0] fault_sel_o;
  logic [31:0] base_o, limit_o;
  logic [7:0]  access_o;
  logic [3:0]  flags_o;

  int checks = 0, fails = 0;
  int nreads;
  logic [31:0] addrs [2];
  logic        seen;

  always #4 clk = ~clk;

  seg_desc_loader i_seg_desc_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .real_mode_i(real_mode_i),
    .sel_i(sel_i), .kind_i(kind_i),
    .gdt_base_i(GDT_B), .gdt_limit_i(GDT_L), .ldt_base_i(LDT_B), .ldt_limit_i(LDT_L),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .done_o(done_o), .fault_o(fault_o), .fault_np_o(fault_np_o),
    .fault_sel_o(fault_sel_o), .unusable_o(unusable_o),
    .base_o(base_o), .limit_o(limit_o), .access_o(access_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [15:0] s);
    logic [31:0] b;
    b = s[2] ? LDT_B : GDT_B;
    return b + 32'(s >> 3) * 32'd8;
  endfunction

  task automatic load(input logic [1:0] k, input logic [15:0] s, input logic rm,
                      input logic [31:0] lo, input logic [31:0] hi, input int stall);
    int stall_left;
    stall_left = stall;
    @(negedge clk);
    kind_i = k; sel_i = s; real_mode_i = rm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    nreads = 0; seen = 1'b0;
    addrs[0] = '0; addrs[1] = '0;
    for (int c = 0; c < 60; c++) begin
      if (done_o) begin seen = 1'b1; break; end
      if (rd_valid_o && stall_left > 0) begin
        stall_left--;
        @(negedge clk);
      end else if (rd_valid_o) begin
        if (nreads < 2) addrs[nreads] = rd_addr_o;
        rd_ready_i = 1'b1;
        @(negedge clk);
        rd_ready_i = 1'b0;
        rsp_data_i = (nreads == 0) ? lo : hi;
        nreads++;
        rsp_valid_i = 1'b1;
        @(negedge clk);
        rsp_valid_i = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check("R13", "done seen", 32'(seen), 32'd1);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    check("R13", "done falls", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13", "reset done", 32'(done_o), 32'd0);
    check("R13", "reset rd_valid", 32'(rd_valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VECS[v].kind, VECS[v].sel, 1'b0, VECS[v].lo, VECS[v].hi, 0);
      check("R1", "read count", 32'(nreads), 32'd2);
      check("R1", "low addr", addrs[0], exp_addr(VECS[v].sel));
      check("R1", "high addr", addrs[1], exp_addr(VECS[v].sel) + 32'd4);
      check("R11", "fault", 32'(fault_o), 32'(VECS[v].gp | VECS[v].np));
      check("R11", "np kind", 32'(fault_np_o), 32'(VECS[v].np));
      check("R13", "fault sel", 32'(fault_sel_o), 32'(VECS[v].sel));
      check("R4", "base", base_o, VECS[v].base);
      check("R5", "limit", limit_o, VECS[v].limit);
      check("R4", "access", 32'(access_o), (VECS[v].gp | VECS[v].np) ? 32'd0 : 32'(VECS[v].hi[15:8]));
      check("R4", "flags", 32'(flags_o), (VECS[v].gp | VECS[v].np) ? 32'd0 : 32'(VECS[v].hi[23:20]));
      after_pulse();
    end

    // R12 real mode shortcut
    load(2'd0, 16'h1234, 1'b1, '0, '0, 0);
    check("R12", "no reads", 32'(nreads), 32'd0);
    check("R12", "base", base_o, 32'h00012340);
    check("R12", "limit", limit_o, 32'h0000FFFF);
    check("R12", "access", 32'(access_o), 32'h93);
    check("R12", "fault", 32'(fault_o), 32'd0);
    after_pulse();

    // R3 null selector into data
    load(2'd2, 16'h0003, 1'b0, '0, '0, 0);
    check("R3", "data null reads", 32'(nreads), 32'd0);
    check("R3", "data null unusable", 32'(unusable_o), 32'd1);
    check("R3", "data null fault", 32'(fault_o), 32'd0);
    // R3 null into stack and code
    load(2'd1, 16'h0000, 1'b0, '0, '0, 0);
    check("R3", "stack null fault", 32'(fault_o), 32'd1);
    check("R3", "stack null unusable", 32'(unusable_o), 32'd0);
    check("R3", "stack null reads", 32'(nreads), 32'd0);
    load(2'd0, 16'h0002, 1'b0, '0, '0, 0);
    check("R3", "code null fault", 32'(fault_o), 32'd1);
    check("R3", "code null sel", 32'(fault_sel_o), 32'h0002);
    // R3 local index 0 is not null
    load(2'd2, 16'h0004, 1'b0, 32'h00000010, 32'h00409200, 0);
    check("R3", "ldt0 reads", 32'(nreads), 32'd2);
    check("R3", "ldt0 addr", addrs[0], 32'h00200000);
    check("R3", "ldt0 unusable", 32'(unusable_o), 32'd0);
    check("R3", "ldt0 fault", 32'(fault_o), 32'd0);

    // R2 bounds on both tables
    load(2'd2, 16'h00F8, 1'b0, 32'h0000FFFF, 32'h00409200, 0);
    check("R2", "gdt at limit reads", 32'(nreads), 32'd2);
    check("R2", "gdt at limit fault", 32'(fault_o), 32'd0);
    load(2'd2, 16'h0100, 1'b0, '0, '0, 0);
    check("R2", "gdt past limit reads", 32'(nreads), 32'd0);
    check("R2", "gdt past limit fault", 32'(fault_o), 32'd1);
    check("R2", "gdt past limit np", 32'(fault_np_o), 32'd0);
    load(2'd2, 16'h0014, 1'b0, 32'h0000FFFF, 32'h00409200, 0);
    check("R2", "ldt at limit reads", 32'(nreads), 32'd2);
    load(2'd2, 16'h001C, 1'b0, '0, '0, 0);
    check("R2", "ldt past limit reads", 32'(nreads), 32'd0);
    check("R2", "ldt past limit fault", 32'(fault_o), 32'd1);
    check("R2", "ldt past limit sel", 32'(fault_sel_o), 32'h001C);

    // R13 stalled request keeps its address
    load(2'd2, 16'h0010, 1'b0, 32'h5678BCDE, 32'h124A9234, 3);
    check("R13", "stall low addr", addrs[0], 32'h00010010);
    check("R13", "stall high addr", addrs[1], 32'h00010014);
    check("R13", "stall base", base_o, 32'h12345678);
    after_pulse();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule